// File: doc/BRIEF.md
# Capture/Compare/PWM Channel

This block is one channel that sits beside a shared 16-bit free-running counter. It watches an external input pin, latches the counter value when a selected pin edge has been seen, compares the counter against a stored 16-bit value, and drives an output pin either by toggling on a compare hit or as a pulse-width modulated level. A module flag reports captures and compare hits to whatever interrupt logic surrounds it. A parameter adds a watchdog role in which a compare hit produces a reset pulse instead of a flag.

Software writes three byte-wide registers: a mode register and the low and high bytes of the capture/compare value. The counter is outside the block; it presents its current value together with a one-cycle `cnt_step` strobe in each cycle in which it has just advanced. All capture, compare and PWM actions happen only on such strobe cycles. Pin edges are held by a four-state pending-edge machine: `PEND_NONE`, `PEND_POS`, `PEND_NEG` and `PEND_BOTH`. Its transitions are *rise* (adds the positive pending), *fall* (adds the negative pending), *take* (a capture consumes the pending edge or edges that triggered it) and *flush* (a mode write that changes the mode returns to `PEND_NONE` from any state).

Mode register bits: bit0 positive-edge capture, bit1 negative-edge capture, bit2 compare enable, bit3 match enable, bit4 toggle, bit5 PWM, bit6 watchdog arm (stored only when `WDT_EN` is 1), bit7 always reads 0. Register select `wr_sel`: 0 mode, 1 compare low byte, 2 compare high byte, 3 no register.

Top module: `ccp_channel`

## Requirements
- R1: Reset (rst_n low) clears the mode register, both compare bytes, the flag and `wdt_rst`, empties the pending-edge state, and sets `pin_out` to 1.
- R2: The pin passes through a two-flop synchronizer reset to 1; a 0-to-1 change adds a pending positive edge and a 1-to-0 change a pending negative edge, which become usable by a strobe three clock edges after the change is first sampled.
- R3: On a strobe, if (bit0 and a positive edge pending) or (bit1 and a negative edge pending), the counter low and high bytes are copied to the compare bytes, the flag is set on the next cycle, and each pending edge that triggered the capture is consumed.
- R4: A mode write whose masked value differs from the current mode empties the pending-edge state; a write of the same value leaves it untouched.
- R5: While bit3 or bit4 is set, a write to the compare low byte clears bit2 and a write to the compare high byte sets bit2.
- R6: On a strobe with bit2 set and the 16-bit counter equal to the compare value, the flag is set; if bit4 is also set and bit5 is clear, `pin_out` inverts.
- R7: On a strobe with bit5 set and counter low byte 0, the compare low byte is reloaded from the high byte; on a strobe with bit5 and bit2 set, `pin_out` becomes 0 if the counter low byte is below the low byte in effect (the reloaded one in a reload cycle) and 1 otherwise.
- R8: With `WDT_EN`=1 and bit6 set, a compare hit gives a one-cycle `wdt_rst` pulse and neither sets the flag nor toggles the pin; with `WDT_EN`=0 bit6 always reads 0.
- R9: `flag_clr` clears the flag; a flag set in the same cycle wins.
- R10: A register write in the same cycle as a capture or reload takes priority for the written byte; without a write or strobe the compare bytes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 low byte, 2 high byte, 3 none |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the module flag |
| cnt_step | input | 1 | Counter advanced this cycle |
| cnt_lo | input | 8 | Counter low byte |
| cnt_hi | input | 8 | Counter high byte |
| pin_in | input | 1 | External pin, asynchronous |
| pin_out | output | 1 | Toggle/PWM output pin |
| flag | output | 1 | Capture or compare flag |
| cmp_lo | output | 8 | Compare/capture low byte |
| cmp_hi | output | 8 | Compare/capture high byte |
| mode_q | output | 8 | Mode register |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
A wrong pending-edge state cannot be read directly; it appears as a capture that is missing or extra at the next strobe after an edge, visible on `cmp_lo`/`cmp_hi` and `flag` one cycle later. A wrong compare enable or reload shows up on `mode_q` in the cycle after the write, and on `pin_out` or `flag` one cycle after the next strobe. The bench therefore compares every output against an independent behavioural model on every clock, including a long pseudo-random stretch, so any divergence surfaces within one or two strobes.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int MB_POSCAP = 0;
    localparam int MB_NEGCAP = 1;
    localparam int MB_CMPEN  = 2;
    localparam int MB_MATCH  = 3;
    localparam int MB_TOGGLE = 4;
    localparam int MB_PWM    = 5;
    localparam int MB_WDOG   = 6;
    localparam int MODE_W    = 8;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'b00,
        PEND_POS  = 2'b01,
        PEND_NEG  = 2'b10,
        PEND_BOTH = 2'b11
    } pend_e;

endpackage

// File: rtl/ccp_pin_sync.sv
module ccp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise =  chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] &  last;
endmodule

// File: rtl/ccp_edge_fsm.sv
module ccp_edge_fsm
    import ccp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise,
    input  logic  fall,
    input  logic  take_pos,
    input  logic  take_neg,
    input  logic  flush,
    output pend_e state,
    output logic  pos_pend,
    output logic  neg_pend
);
    pend_e state_nx;
    logic  keep_pos;
    logic  keep_neg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PEND_NONE;
        else        state <= state_nx;
    end

    // next state: take, rise, fall, flush
    always_comb begin
        keep_pos = 1'b0;
        keep_neg = 1'b0;
        unique case (state)
            PEND_NONE: ;
            PEND_POS:  keep_pos = ~take_pos;
            PEND_NEG:  keep_neg = ~take_neg;
            PEND_BOTH: begin
                keep_pos = ~take_pos;
                keep_neg = ~take_neg;
            end
            default: ;
        endcase
        if (flush) state_nx = PEND_NONE;
        else       state_nx = pend_e'({keep_neg | fall, keep_pos | rise});
    end

    // outputs
    always_comb begin
        pos_pend = 1'b0;
        neg_pend = 1'b0;
        unique case (state)
            PEND_NONE: ;
            PEND_POS:  pos_pend = 1'b1;
            PEND_NEG:  neg_pend = 1'b1;
            PEND_BOTH: begin
                pos_pend = 1'b1;
                neg_pend = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ccp_cmp_unit.sv
module ccp_cmp_unit
    import ccp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              cnt_step,
    input  logic [BYTE_W-1:0] cnt_lo,
    input  logic [BYTE_W-1:0] cnt_hi,
    input  logic [BYTE_W-1:0] cmp_lo,
    input  logic [BYTE_W-1:0] cmp_hi,
    output logic              reload,
    output logic [BYTE_W-1:0] eff_lo,
    output logic              match_hit,
    output logic              pwm_drive,
    output logic              pwm_lvl
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] cnt_word;
    logic [WORD_W-1:0] ref_word;

    always_comb begin
        reload    = cnt_step & mode[MB_PWM] & (cnt_lo == '0);
        eff_lo    = reload ? cmp_hi : cmp_lo;
        cnt_word  = {cnt_hi, cnt_lo};
        ref_word  = {cmp_hi, eff_lo};
        match_hit = cnt_step & mode[MB_CMPEN] & (cnt_word == ref_word);
        pwm_drive = cnt_step & mode[MB_PWM] & mode[MB_CMPEN];
        pwm_lvl   = (cnt_lo >= eff_lo);
    end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit WDT_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              cnt_step,
    input  logic [BYTE_W-1:0] cnt_lo,
    input  logic [BYTE_W-1:0] cnt_hi,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              flag,
    output logic [BYTE_W-1:0] cmp_lo,
    output logic [BYTE_W-1:0] cmp_hi,
    output logic [MODE_W-1:0] mode_q,
    output logic              wdt_rst
);
    localparam logic [MODE_W-1:0] MODE_MASK = WDT_EN ? 8'h7F : 8'h3F;

    logic              rise, fall;
    logic              pos_pend, neg_pend;
    pend_e             pend_st;
    logic              take_pos, take_neg, cap_fire;
    logic              reload, match_hit, pwm_drive, pwm_lvl;
    logic [BYTE_W-1:0] eff_lo;
    logic              wdog_armed, wdog_hit;
    logic              wr_mode, wr_lo, wr_hi;
    logic [MODE_W-1:0] mode_wdata;
    logic              mode_chg, en_ctl;

    ccp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    ccp_edge_fsm u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .take_pos(take_pos),
        .take_neg(take_neg),
        .flush   (mode_chg),
        .state   (pend_st),
        .pos_pend(pos_pend),
        .neg_pend(neg_pend)
    );

    ccp_cmp_unit #(.BYTE_W(BYTE_W)) u_cmp (
        .mode     (mode_q),
        .cnt_step (cnt_step),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .cmp_lo   (cmp_lo),
        .cmp_hi   (cmp_hi),
        .reload   (reload),
        .eff_lo   (eff_lo),
        .match_hit(match_hit),
        .pwm_drive(pwm_drive),
        .pwm_lvl  (pwm_lvl)
    );

    generate
        if (WDT_EN) begin : g_wdog
            assign wdog_armed = mode_q[MB_WDOG];
        end else begin : g_no_wdog
            assign wdog_armed = 1'b0;
        end
    endgenerate

    always_comb begin
        wr_mode    = wr_en & (wr_sel == SEL_MODE);
        wr_lo      = wr_en & (wr_sel == SEL_LO);
        wr_hi      = wr_en & (wr_sel == SEL_HI);
        mode_wdata = wr_data[MODE_W-1:0] & MODE_MASK;
        mode_chg   = wr_mode & (mode_wdata != mode_q);
        en_ctl     = mode_q[MB_MATCH] | mode_q[MB_TOGGLE];
        take_pos   = cnt_step & mode_q[MB_POSCAP] & pos_pend;
        take_neg   = cnt_step & mode_q[MB_NEGCAP] & neg_pend;
        cap_fire   = take_pos | take_neg;
        wdog_hit   = match_hit & wdog_armed;
    end

    // register file and output drivers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            cmp_lo  <= '0;
            cmp_hi  <= '0;
            flag    <= 1'b0;
            pin_out <= 1'b1;
            wdt_rst <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_q <= mode_wdata;
            end else if (wr_lo && en_ctl) begin
                mode_q[MB_CMPEN] <= 1'b0;
            end else if (wr_hi && en_ctl) begin
                mode_q[MB_CMPEN] <= 1'b1;
            end

            if (wr_lo)         cmp_lo <= wr_data;
            else if (cap_fire) cmp_lo <= cnt_lo;
            else if (reload)   cmp_lo <= cmp_hi;

            if (wr_hi)         cmp_hi <= wr_data;
            else if (cap_fire) cmp_hi <= cnt_hi;

            if (cap_fire || (match_hit && !wdog_hit)) flag <= 1'b1;
            else if (flag_clr)                        flag <= 1'b0;

            if (pwm_drive) begin
                pin_out <= pwm_lvl;
            end else if (match_hit && !wdog_hit && mode_q[MB_TOGGLE]) begin
                pin_out <= ~pin_out;
            end

            wdt_rst <= wdog_hit;
        end
    end
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk
    import ccp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       cnt_step,
    input logic       pin_out,
    input logic       flag,
    input logic [7:0] cmp_lo,
    input logic [7:0] cmp_hi,
    input logic [7:0] mode_q,
    input logic       wdt_rst,
    input logic       cap_fire,
    input logic       match_hit,
    input logic       pwm_drive,
    input logic       pwm_lvl,
    input logic       wdog_armed,
    input pend_e      pend_st
);
    // R3: a capture raises the flag
    p_cap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> flag);

    // R4: a changing mode write empties the pending state
    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[7:6] == 2'b00 && wr_data[5:0] != mode_q[5:0])
        |=> pend_st == PEND_NONE);

    // R5: low byte write disables the comparator in match/toggle mode
    p_lo_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && (mode_q[3] || mode_q[4])) |=> !mode_q[2]);

    // R5: high byte write enables it again
    p_hi_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && (mode_q[3] || mode_q[4])) |=> mode_q[2]);

    // R6: toggle on compare hit
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && mode_q[4] && !pwm_drive && !wdog_armed) |=> pin_out != $past(pin_out));

    // R7: pwm level follows the comparison
    p_pwm_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_drive |=> pin_out == $past(pwm_lvl));

    // R8: watchdog pulse only after a strobe, and never alongside a fresh match flag
    p_wdog_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(cnt_step));

    p_wdog_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && wdog_armed && !cap_fire && !flag) |=> !flag);

    // R10: compare bytes hold without write or strobe
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cnt_step) |=> ($stable(cmp_lo) && $stable(cmp_hi)));
endmodule

bind ccp_channel ccp_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cnt_step  (cnt_step),
    .pin_out   (pin_out),
    .flag      (flag),
    .cmp_lo    (cmp_lo),
    .cmp_hi    (cmp_hi),
    .mode_q    (mode_q),
    .wdt_rst   (wdt_rst),
    .cap_fire  (cap_fire),
    .match_hit (match_hit),
    .pwm_drive (pwm_drive),
    .pwm_lvl   (pwm_lvl),
    .wdog_armed(wdog_armed),
    .pend_st   (pend_st)
);

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       cnt_step = 1'b0;
    logic [7:0] cnt_lo = '0;
    logic [7:0] cnt_hi = '0;
    logic       pin_in = 1'b1;
    logic       pin_out, flag, wdt_rst;
    logic [7:0] cmp_lo, cmp_hi, mode_q;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ccp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .cnt_step(cnt_step),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .pin_in(pin_in),
        .pin_out(pin_out), .flag(flag), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .mode_q(mode_q), .wdt_rst(wdt_rst)
    );

    // behavioural reference
    bit       pin_hist[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
    bit       m_pp = 0, m_pn = 0, m_flag = 0, m_pin = 1, m_wdt = 0;
    bit [7:0] m_mode = 0, m_lo = 0, m_hi = 0;

    always @(posedge clk) begin
        bit rise, fall, tp, tn, cap, rel, hit, wd, wm, wl, wh, chg;
        bit [7:0] elo, nlo, nhi, nmode;
        if (!rst_n) begin
            pin_hist = '{1'b1, 1'b1, 1'b1, 1'b1};
            m_pp = 0; m_pn = 0; m_flag = 0; m_pin = 1; m_wdt = 0;
            m_mode = 0; m_lo = 0; m_hi = 0;
        end else begin
            pin_hist.push_front(pin_in);
            void'(pin_hist.pop_back());
            rise = pin_hist[2] && !pin_hist[3];
            fall = !pin_hist[2] && pin_hist[3];
            tp   = cnt_step && m_mode[0] && m_pp;
            tn   = cnt_step && m_mode[1] && m_pn;
            cap  = tp || tn;
            rel  = cnt_step && m_mode[5] && (cnt_lo == 0);
            elo  = rel ? m_hi : m_lo;
            hit  = cnt_step && m_mode[2] && (cnt_lo == elo) && (cnt_hi == m_hi);
            wd   = hit && m_mode[6];
            wm   = wr_en && wr_sel == 2'd0;
            wl   = wr_en && wr_sel == 2'd1;
            wh   = wr_en && wr_sel == 2'd2;
            chg  = wm && ((wr_data & 8'h7F) != m_mode);
            nlo  = wl ? wr_data : (cap ? cnt_lo : (rel ? m_hi : m_lo));
            nhi  = wh ? wr_data : (cap ? cnt_hi : m_hi);
            if (wm) nmode = wr_data & 8'h7F;
            else if (wl && (m_mode[3] || m_mode[4])) nmode = m_mode & 8'hFB;
            else if (wh && (m_mode[3] || m_mode[4])) nmode = m_mode | 8'h04;
            else nmode = m_mode;
            if (cap || (hit && !wd)) m_flag = 1;
            else if (flag_clr)       m_flag = 0;
            if (cnt_step && m_mode[5] && m_mode[2]) m_pin = (cnt_lo >= elo);
            else if (hit && !wd && m_mode[4])       m_pin = !m_pin;
            m_pp   = chg ? 1'b0 : ((m_pp && !tp) || rise);
            m_pn   = chg ? 1'b0 : ((m_pn && !tn) || fall);
            m_wdt  = wd;
            m_lo   = nlo;
            m_hi   = nhi;
            m_mode = nmode;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (pin_out !== m_pin || flag !== m_flag || cmp_lo !== m_lo ||
                cmp_hi !== m_hi || mode_q !== m_mode || wdt_rst !== m_wdt) begin
                n_bad++;
                $display("FAIL %s t=%0t act pin=%0b flag=%0b lo=%02h hi=%02h mode=%02h wdt=%0b exp pin=%0b flag=%0b lo=%02h hi=%02h mode=%02h wdt=%0b",
                    cur_req, $time, pin_out, flag, cmp_lo, cmp_hi, mode_q, wdt_rst,
                    m_pin, m_flag, m_lo, m_hi, m_mode, m_wdt);
            end
        end
    end

    task automatic cyc(input bit we, input bit [1:0] sel, input bit [7:0] d,
                       input bit st, input bit [7:0] lo, input bit [7:0] hi, input bit clr);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d;
        cnt_step = st; cnt_lo = lo; cnt_hi = hi; flag_clr = clr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd3, 8'h00, 0, 8'h00, 8'h00, 0);
    endtask

    task automatic wr(input bit [1:0] sel, input bit [7:0] d);
        cyc(1, sel, d, 0, 8'h00, 8'h00, 0);
    endtask

    task automatic step(input bit [7:0] lo, input bit [7:0] hi);
        cyc(0, 2'd3, 8'h00, 1, lo, hi, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            finish_run();
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2, R3: positive edge capture, consumption
        cur_req = "R2_R3";
        wr(2'd0, 8'h01);
        setpin(0); idle(5); setpin(1); idle(5);
        step(8'h34, 8'h12);
        idle(2);
        step(8'h00, 8'h20);
        idle(2);
        // R9: clear flag
        cur_req = "R9";
        cyc(0, 2'd3, 8'h00, 0, 8'h00, 8'h00, 1);
        idle(1);
        // R4: changing mode write flushes pending
        cur_req = "R4";
        setpin(0); idle(5);
        wr(2'd0, 8'h03);
        step(8'h44, 8'h33);
        idle(1);
        setpin(1); idle(5);
        wr(2'd0, 8'h03);
        step(8'h55, 8'h44);
        idle(2);
        // R5, R6: compare enable control and toggle
        cur_req = "R5_R6";
        cyc(0, 2'd3, 8'h00, 0, 8'h00, 8'h00, 1);
        wr(2'd0, 8'h1C);
        wr(2'd1, 8'h10);
        idle(1);
        wr(2'd2, 8'h20);
        step(8'h10, 8'h20);
        step(8'h11, 8'h20);
        step(8'h10, 8'h20);
        idle(1);
        wr(2'd0, 8'h04);
        cyc(0, 2'd3, 8'h00, 0, 8'h00, 8'h00, 1);
        step(8'h10, 8'h20);
        idle(1);
        // R7: pwm reload and level
        cur_req = "R7";
        wr(2'd0, 8'h24);
        wr(2'd2, 8'h40);
        step(8'h00, 8'h01);
        step(8'h3F, 8'h01);
        step(8'h40, 8'h01);
        step(8'h80, 8'h01);
        wr(2'd2, 8'h10);
        step(8'h05, 8'h01);
        step(8'h00, 8'h02);
        step(8'h20, 8'h02);
        idle(1);
        // R8: watchdog match
        cur_req = "R8";
        wr(2'd0, 8'h44);
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h66);
        cyc(0, 2'd3, 8'h00, 0, 8'h00, 8'h00, 1);
        step(8'h55, 8'h66);
        idle(2);
        // R10: write wins over capture
        cur_req = "R10";
        wr(2'd0, 8'h01);
        setpin(0); idle(4); setpin(1); idle(5);
        cyc(1, 2'd1, 8'h99, 1, 8'h77, 8'h88, 0);
        idle(2);
        // mixed stimulus
        cur_req = "R3_R6_R7_mix";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) setpin(~pin_in);
            cyc(lfsr[7:5] == 3'b000, lfsr[9:8], {1'b0, lfsr[14:8]},
                lfsr[4], {4'h0, lfsr[11:10], lfsr[1:0]}, {7'h0, lfsr[12]},
                lfsr[15:13] == 3'b111);
        end
        idle(3);
        finish_run();
    end

    task automatic setpin(input bit v);
        pin_in = v;
    endtask
endmodule